// File: doc/BRIEF.md
# Comparator Change-Interrupt Unit

This block takes the one-bit digital outputs of two comparators and conditions them. Each output has its own polarity inversion, and each can drive a pin in place of the general-purpose output value. The block also detects when a comparator output changes and raises a per-comparator interrupt flag. It does not use an edge detector for this. It keeps a stored copy of both conditioned outputs and compares the live values against that copy.

A flag sets whenever a live output disagrees with the stored copy. While the disagreement lasts, clearing the flag has no lasting effect. The stored copy is refreshed only when software reads or writes the status register, and that access is what ends the mismatch. Software can also write the flags directly, which makes it possible to force an interrupt for testing. The interrupt request is a three-level AND of the per-comparator enable, the peripheral enable and the global enable. The flags themselves ignore these enables.

Top module: `cmp_chg_irq`

## Requirements
- R1: After reset, both flags, both invert controls and the stored copy are 0, so `stat_rdata` reads 0 and `irq` is 0.
- R2: `stat_rdata` is {invert[1:0], out[1:0]}. Each out bit is the raw input after a two-flop synchronizer, XOR the invert bit. A raw change shows in `stat_rdata` after two rising edges.
- R3: When `pin_mode` is 1, `pin_out` is the unsynchronized raw input XOR the invert bit, with no clock delay. When `pin_mode` is 0, `pin_out` is `gpio_out`. `pin_oe` always equals `pin_drv_en`.
- R4: When an out bit differs from its stored-copy bit in a cycle with no status access, the matching flag is 1 after the next rising edge.
- R5: While that mismatch persists, writing 0 to the flag leaves it at 1.
- R6: A status read (`stat_rd`) or a status write (`stat_wr`) loads the stored copy with the conditioned outputs and ends the mismatch. A write also loads the invert bits from `stat_wdata`, and the copy is taken with the new invert values.
- R7: `flag_wr` loads the flags from `flag_wdata`. Writing 1 sets a flag with no mismatch present; writing 0 clears a flag when no mismatch is present.
- R8: In a cycle with a status access, a mismatch does not set a flag, because the capture takes priority.
- R9: `irq` is 1 only when some flag is 1 with its `cmp_ie` bit set and both `periph_ie` and `global_ie` are 1. The flags still set when any enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 2 | Raw comparator outputs |
| gpio_out | input | 2 | General-purpose pin value used when pin mode is off |
| pin_drv_en | input | 2 | Per-pin tri-state drive enable |
| pin_mode | input | 1 | 1 routes the comparator outputs to the pins |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 2 | Invert bits written on a status write |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | 2 | Flag values to write |
| cmp_ie | input | 2 | Per-comparator interrupt enables |
| periph_ie | input | 1 | Peripheral interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| stat_rdata | output | 4 | {invert[1:0], out[1:0]} |
| flags | output | 2 | Per-comparator change flags |
| pin_out | output | 2 | Pin output values |
| pin_oe | output | 2 | Pin output enables |
| irq | output | 1 | Interrupt request |

## Verification
A stale or wrongly loaded stored copy shows at the `flags` port one edge after the conditioned output becomes visible. It appears either as a flag that sets with no input change or as a flag that cannot be cleared. A wrong invert bit shows at once in `stat_rdata` and `pin_out`, and a synchronizer of the wrong depth shifts the status bits by one cycle. The capture-priority race is checked by putting a read strobe on exactly the edge where the synchronized value first differs from the copy. If flag setting wins that race, a flag appears that the bench does not expect.

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq #(
  parameter int N = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   cmp_raw,
  input  logic [N-1:0]   gpio_out,
  input  logic [N-1:0]   pin_drv_en,
  input  logic           pin_mode,
  input  logic           stat_rd,
  input  logic           stat_wr,
  input  logic [N-1:0]   stat_wdata,
  input  logic           flag_wr,
  input  logic [N-1:0]   flag_wdata,
  input  logic [N-1:0]   cmp_ie,
  input  logic           periph_ie,
  input  logic           global_ie,
  output logic [2*N-1:0] stat_rdata,
  output logic [N-1:0]   flags,
  output logic [N-1:0]   pin_out,
  output logic [N-1:0]   pin_oe,
  output logic           irq
);

  logic [N-1:0] sync1, sync2, inv_q, copy_q, flag_q;
  logic [N-1:0] cond, flag_next;
  logic         access;

  assign cond      = sync2 ^ inv_q;
  assign access    = stat_rd | stat_wr;
  assign flag_next = (flag_wr ? flag_wdata : flag_q) | (access ? '0 : (cond ^ copy_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      inv_q  <= '0;
      copy_q <= '0;
      flag_q <= '0;
    end else begin
      sync1  <= cmp_raw;
      sync2  <= sync1;
      flag_q <= flag_next;
      if (stat_wr) inv_q <= stat_wdata;
      if (access) copy_q <= sync2 ^ (stat_wr ? stat_wdata : inv_q);
    end
  end

  assign stat_rdata = {inv_q, cond};
  assign flags      = flag_q;
  assign pin_out    = pin_mode ? (cmp_raw ^ inv_q) : gpio_out;
  assign pin_oe     = pin_drv_en;
  assign irq        = (|(flag_q & cmp_ie)) & periph_ie & global_ie;

endmodule

// File: rtl/cmp_chg_irq_chk.sv
module cmp_chg_irq_chk #(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stat_rd,
  input logic         stat_wr,
  input logic         flag_wr,
  input logic [N-1:0] flag_wdata,
  input logic [N-1:0] flags,
  input logic         irq,
  input logic         periph_ie,
  input logic         global_ie,
  input logic [N-1:0] cond,
  input logic [N-1:0] copy_q
);

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (periph_ie && global_ie && (flags != '0))); // R9

  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> ($past(flag_wr && flag_wdata[0]) ||
                         $past((cond[0] != copy_q[0]) && !stat_rd && !stat_wr))); // R4

  AST_MISMATCH_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cond != copy_q) && !stat_rd && !stat_wr) |=> ((flags & $past(cond ^ copy_q)) == $past(cond ^ copy_q))); // R5

  AST_CAPTURE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_rd || stat_wr) && !flag_wr && (flags == '0)) |=> (flags == '0)); // R8

  AST_READ_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !stat_wr) |=> (copy_q == $past(cond))); // R6

endmodule

bind cmp_chg_irq cmp_chg_irq_chk #(.N(N)) u_chk (.*);

// File: tb/cmp_chg_irq_bench.sv
`timescale 1ns/1ps
module cmp_chg_irq_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] cmp_raw = 0, gpio_out = 0, pin_drv_en = 0, stat_wdata = 0, flag_wdata = 0, cmp_ie = 0;
  logic pin_mode = 0, stat_rd = 0, stat_wr = 0, flag_wr = 0, periph_ie = 0, global_ie = 0;
  logic [3:0] stat_rdata;
  logic [1:0] flags, pin_out, pin_oe;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cmp_chg_irq u_cmp_chg_irq (.*);

  // {raw[2], rd, wr, wdata[2], fwr, fwdata[2], exp_flags[2], exp_stat[4]}
  localparam logic [14:0] VEC [10] = '{
    15'b01_0_0_00_0_00_01_0001, // R4 mismatch sets flag
    15'b01_0_0_00_1_00_01_0001, // R5 clear while mismatch
    15'b01_1_0_00_0_00_01_0001, // R6 read copies
    15'b01_0_0_00_1_00_00_0001, // R7 clear
    15'b01_0_0_00_1_10_10_0001, // R7 force
    15'b01_0_0_00_1_00_00_0001, // R7 clear
    15'b11_0_0_00_0_00_10_0011, // R4 second comparator
    15'b11_0_1_11_0_00_10_1100, // R6 write sets invert and copy
    15'b11_0_0_00_1_00_00_1100, // R6 no mismatch after write
    15'b00_0_0_00_0_00_11_1111  // R2 inverted outputs
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cmp_raw = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1 flags", {6'd0, flags}, 8'd0);
    chk("R1 stat", {4'd0, stat_rdata}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    cmp_raw = 2'b00;
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      cmp_raw = VEC[i][14:13]; stat_rd = VEC[i][12]; stat_wr = VEC[i][11];
      stat_wdata = VEC[i][10:9]; flag_wr = VEC[i][8]; flag_wdata = VEC[i][7:6];
      @(negedge clk);
      stat_rd = 0; stat_wr = 0; flag_wr = 0;
      repeat (3) @(negedge clk);
      chk($sformatf("R4/R5/R6/R7 vec%0d flags", i), {6'd0, flags}, {6'd0, VEC[i][5:4]});
      chk($sformatf("R2 vec%0d stat", i), {4'd0, stat_rdata}, {4'd0, VEC[i][3:0]});
    end

    // R9 enable gating, flags are 11 here
    cmp_ie = 2'b01; periph_ie = 1; global_ie = 1; #1;
    chk("R9 all enabled", {7'd0, irq}, 8'd1);
    global_ie = 0; #1;
    chk("R9 global off", {7'd0, irq}, 8'd0);
    global_ie = 1; periph_ie = 0; #1;
    chk("R9 periph off", {7'd0, irq}, 8'd0);
    periph_ie = 1; cmp_ie = 2'b00; #1;
    chk("R9 cmp_ie off", {7'd0, irq}, 8'd0);
    chk("R9 flags kept", {6'd0, flags}, 8'h03);

    // resync copy and clear flags in one cycle
    @(negedge clk); stat_rd = 1; flag_wr = 1; flag_wdata = 0;
    @(negedge clk); stat_rd = 0; flag_wr = 0;
    @(negedge clk);
    chk("R6 R7 cleared", {6'd0, flags}, 8'd0);

    // R8 race: read strobe on the edge where the synchronized value first differs
    cmp_raw = 2'b11;
    @(negedge clk);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    @(negedge clk); @(negedge clk);
    chk("R8 capture wins", {6'd0, flags}, 8'd0);
    chk("R8 stat", {4'd0, stat_rdata}, 8'h0c);

    // R3 pin path
    pin_mode = 1; pin_drv_en = 2'b10; #1;
    chk("R3 pin inverted", {6'd0, pin_out}, 8'h00);
    chk("R3 oe", {6'd0, pin_oe}, 8'h02);
    cmp_raw = 2'b01; #1;
    chk("R3 unsynchronized", {6'd0, pin_out}, 8'h02);
    pin_mode = 0; gpio_out = 2'b01; #1;
    chk("R3 gpio", {6'd0, pin_out}, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule